// File: doc/BRIEF.md
# Trim Programming Controller

This block steers end-of-line calibration of a pulse-width sensor output stage. It receives two kinds of one-cycle events, a mid-level pulse and a high-level pulse, decoded upstream from the shared output/programming pin. From these events it picks one of several trim registers and raises that register's trial code step by step. It can also commit a single bit of the code into a one-time fuse store. The outputs are the effective trim words that the carrier generator and modulator use, and each of those words is the bitwise OR of the volatile trial code and the fuses already committed.

A session starts with a high pulse. Counting mid pulses then forms a key that names the register. A second high pulse opens that register for trial, and every later mid pulse adds one to its code. A final high pulse asks to commit the addressed bit. Only one commit is taken per power cycle. A committed lock fuse freezes the controller from then on. Two resets are kept apart: the power-cycle reset drops the trial state only, and the hard reset also clears the fuse model.

Top module: `trim_prog_ctrl`

## Requirements
- R1: After a hard reset every trim output, `locked`, `blow_req` and `blow_err` read 0.
- R2: Mid events received before the first high event of a session are ignored and do not add to the key.
- R3: A high event in the idle phase starts key counting at 0. Each mid event adds 1 to the key, and the key stops at 7. The next high event opens the register named by the key. Key 1 maps to sensitivity bits 7:0 and the unidirectional select in bit 8. Key 2 maps to the 9-bit fine quiescent word. Key 3 maps to carrier frequency bits 3:0 and the calibration hold in bit 4. Key 5 maps to the 10-bit lock register, where only bit 9 counts. Every other key selects nothing, and mid events under it change no output.
- R4: While a register is open, each mid event raises its trial code by exactly 1. The code stops at the register's all-ones value (9, 9, 5 and 10 bits for keys 1, 2, 3 and 5). There is no way to lower it.
- R5: Each trim output equals trial code OR committed fuses. A power-cycle reset clears the trial code.
- R6: A high event in the open phase whose trial code has exactly one bit set, and that bit is committable, sets that fuse. In the next cycle `blow_req` is high for one cycle, with `blow_key` holding the key and `blow_bit` holding the bit position. Fuses survive power-cycle resets and are cleared only by a hard reset.
- R7: After any commit request, accepted or rejected, every event is ignored until the next power-cycle reset.
- R8: Only the open register carries a trial code. Every other register shows its fuse value alone.
- R9: `locked` mirrors the committed lock fuse (key 5, bit 9). While it is set, no event changes any output.
- R10: A commit request is rejected when the code is zero, has several bits set, comes under a null key, or sits on a lock register bit other than 9. A rejected request sets the sticky `blow_err` until the next power-cycle reset, raises no `blow_req` and changes no fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low full reset, clears fuses too |
| pwr_rst_n | input | 1 | Asynchronous active-low power-cycle reset, keeps fuses |
| mid_ev | input | 1 | One-cycle mid-level pulse event |
| high_ev | input | 1 | One-cycle high-level pulse event |
| sens_trim | output | 8 | Effective sensitivity code |
| uni_mode | output | 1 | Effective unidirectional quiescent select |
| qfine_trim | output | 9 | Effective fine quiescent code |
| freq_trim | output | 4 | Effective carrier frequency code |
| cal_hold | output | 1 | Effective calibration-hold enable |
| locked | output | 1 | Lock fuse committed |
| blow_req | output | 1 | One-cycle fuse commit strobe |
| blow_key | output | 3 | Key of the last commit |
| blow_bit | output | 4 | Bit position of the last commit |
| blow_err | output | 1 | Sticky rejected-commit flag |

## Verification
The hardest state to reach is the frozen one. The lock bit sits at code 512, so the stimulus has to open key 5 and deliver 512 mid events before a commit. That commit must also come only after a rejected attempt on bit 0 of the same register. The bench then power-cycles the block and replays a full frequency-trim session, which has to leave every port untouched. Fuse persistence is reached by committing a frequency bit and power-cycling. A new trial on a different register then has to show both values at once, while a further trial on the same register has to show their OR.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int W_MAX     = 10;
  localparam int N_SLOT    = 4;
  localparam int KEY_W     = 3;
  localparam int BIT_W     = $clog2(W_MAX);
  localparam int LOCK_SLOT = 3;
  localparam int LOCK_BIT  = 9;
  localparam int SENS_W    = 8;
  localparam int QFINE_W   = 9;
  localparam int FREQ_W    = 4;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_SEL  = 2'd1,
    PS_ADDR = 2'd2,
    PS_HOLD = 2'd3
  } prog_st_t;

  // key that addresses each slot
  function automatic int slot_key(input int i);
    case (i)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int slot_width(input int i);
    case (i)
      0:       return 9;
      1:       return 9;
      2:       return 5;
      default: return 10;
    endcase
  endfunction

  // bits of a slot that may be committed to fuse
  function automatic logic [W_MAX-1:0] slot_mask(input int i);
    if (i == LOCK_SLOT) return W_MAX'(1) << LOCK_BIT;
    return W_MAX'((1 << slot_width(i)) - 1);
  endfunction
endpackage

// File: rtl/trim_rst_sync.sv
module trim_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/trim_slot.sv
module trim_slot
  import trim_pkg::*;
#(
  parameter int               W    = 9,
  parameter logic [W_MAX-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             hard_n,
  input  logic             soft_n,
  input  logic             inc_en,
  input  logic             blow_en,
  output logic [W_MAX-1:0] act_o,
  output logic [W_MAX-1:0] fuse_o
);
  localparam logic [W-1:0] CODE_MAX = '1;

  logic [W-1:0] act_q, act_d;
  logic [W-1:0] fuse_q, fuse_d;

  always_comb begin
    act_d = act_q;
    if (inc_en && act_q != CODE_MAX) act_d = act_q + W'(1);
  end

  always_comb begin
    fuse_d = fuse_q;
    if (blow_en) fuse_d = fuse_q | (act_q & MASK[W-1:0]);
  end

  // volatile trial code: lost on any power cycle
  always_ff @(posedge clk or negedge soft_n) begin
    if (!soft_n) act_q <= '0;
    else         act_q <= act_d;
  end

  // fuse model: survives power cycles
  always_ff @(posedge clk or negedge hard_n) begin
    if (!hard_n) fuse_q <= '0;
    else         fuse_q <= fuse_d;
  end

  assign act_o  = W_MAX'(act_q);
  assign fuse_o = W_MAX'(fuse_q);
endmodule

// File: rtl/trim_prog_fsm.sv
module trim_prog_fsm
  import trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mid_ev,
  input  logic             high_ev,
  input  logic             lock_fuse,
  input  logic             sel_hit,
  input  logic [W_MAX-1:0] sel_code,
  input  logic [W_MAX-1:0] sel_mask,
  output logic [KEY_W-1:0] sel_key,
  output logic             inc_en,
  output logic             blow_en,
  output logic             blow_req,
  output logic [KEY_W-1:0] blow_key,
  output logic [BIT_W-1:0] blow_bit,
  output logic             blow_err
);
  localparam logic [KEY_W-1:0] KEY_MAX = '1;

  prog_st_t         st_q, st_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             err_q, err_set;
  logic             req_q;
  logic [KEY_W-1:0] bkey_q;
  logic [BIT_W-1:0] bbit_q, bit_d;
  logic             code_ok;

  always_comb begin
    code_ok = sel_hit && ($countones(sel_code) == 1) &&
              ((sel_code & ~sel_mask) == '0);
    bit_d = '0;
    for (int b = 0; b < W_MAX; b++) begin
      if (sel_code[b]) bit_d = BIT_W'(b);
    end
  end

  always_comb begin
    st_d    = st_q;
    key_d   = key_q;
    inc_en  = 1'b0;
    blow_en = 1'b0;
    err_set = 1'b0;
    if (!lock_fuse) begin
      case (st_q)
        PS_IDLE: begin
          if (high_ev) begin
            st_d  = PS_SEL;
            key_d = '0;
          end
        end
        PS_SEL: begin
          if (high_ev) st_d = PS_ADDR;
          else if (mid_ev && key_q != KEY_MAX) key_d = key_q + KEY_W'(1);
        end
        PS_ADDR: begin
          if (high_ev) begin
            st_d    = PS_HOLD;
            blow_en = code_ok;
            err_set = !code_ok;
          end else if (mid_ev) begin
            inc_en = sel_hit;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      key_q <= '0;
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      key_q <= key_d;
      err_q <= err_q | err_set;
      req_q <= blow_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkey_q <= '0;
      bbit_q <= '0;
    end else if (blow_en) begin
      bkey_q <= key_q;
      bbit_q <= bit_d;
    end
  end

  assign sel_key  = key_q;
  assign blow_req = req_q;
  assign blow_key = bkey_q;
  assign blow_bit = bbit_q;
  assign blow_err = err_q;
endmodule

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_pkg::*;
(
  input  logic               clk,
  input  logic               hard_rst_n,
  input  logic               pwr_rst_n,
  input  logic               mid_ev,
  input  logic               high_ev,
  output logic [SENS_W-1:0]  sens_trim,
  output logic               uni_mode,
  output logic [QFINE_W-1:0] qfine_trim,
  output logic [FREQ_W-1:0]  freq_trim,
  output logic               cal_hold,
  output logic               locked,
  output logic               blow_req,
  output logic [KEY_W-1:0]   blow_key,
  output logic [BIT_W-1:0]   blow_bit,
  output logic               blow_err
);
  logic hard_n, soft_n;
  logic [N_SLOT-1:0][W_MAX-1:0] act_a, fuse_a, eff_a;
  logic [KEY_W-1:0] sel_key;
  logic             sel_hit;
  logic [W_MAX-1:0] sel_code, sel_mask;
  logic             inc_en, blow_en, lock_fuse;

  trim_rst_sync u_hard_sync (.clk(clk), .arst_n(hard_rst_n), .srst_n(hard_n));
  trim_rst_sync u_soft_sync (.clk(clk), .arst_n(hard_rst_n & pwr_rst_n), .srst_n(soft_n));

  always_comb begin
    sel_hit  = 1'b0;
    sel_code = '0;
    sel_mask = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (sel_key == KEY_W'(slot_key(i))) begin
        sel_hit  = 1'b1;
        sel_code = act_a[i];
        sel_mask = slot_mask(i);
      end
    end
  end

  generate
    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      logic hit;
      assign hit = (sel_key == KEY_W'(slot_key(g)));
      trim_slot #(
        .W    (slot_width(g)),
        .MASK (slot_mask(g))
      ) u_slot (
        .clk     (clk),
        .hard_n  (hard_n),
        .soft_n  (soft_n),
        .inc_en  (inc_en & hit),
        .blow_en (blow_en & hit),
        .act_o   (act_a[g]),
        .fuse_o  (fuse_a[g])
      );
      assign eff_a[g] = act_a[g] | fuse_a[g];
    end
  endgenerate

  assign lock_fuse = fuse_a[LOCK_SLOT][LOCK_BIT];

  trim_prog_fsm u_fsm (
    .clk       (clk),
    .rst_n     (soft_n),
    .mid_ev    (mid_ev),
    .high_ev   (high_ev),
    .lock_fuse (lock_fuse),
    .sel_hit   (sel_hit),
    .sel_code  (sel_code),
    .sel_mask  (sel_mask),
    .sel_key   (sel_key),
    .inc_en    (inc_en),
    .blow_en   (blow_en),
    .blow_req  (blow_req),
    .blow_key  (blow_key),
    .blow_bit  (blow_bit),
    .blow_err  (blow_err)
  );

  assign sens_trim  = eff_a[0][SENS_W-1:0];
  assign uni_mode   = eff_a[0][SENS_W];
  assign qfine_trim = eff_a[1][QFINE_W-1:0];
  assign freq_trim  = eff_a[2][FREQ_W-1:0];
  assign cal_hold   = eff_a[2][FREQ_W];
  assign locked     = lock_fuse;
endmodule

// File: rtl/trim_prog_chk.sv
module trim_prog_chk
  import trim_pkg::*;
(
  input logic                      clk,
  input logic                      hard_n,
  input logic                      soft_n,
  input logic                      blow_req,
  input logic                      blow_err,
  input logic                      lock_fuse,
  input logic [N_SLOT*W_MAX-1:0]   fuse_vec,
  input logic [N_SLOT*W_MAX-1:0]   act_vec
);
  logic [N_SLOT-1:0] busy;

  always_comb begin
    for (int i = 0; i < N_SLOT; i++) busy[i] = |act_vec[i*W_MAX +: W_MAX];
  end

  AST_FUSE_ONE_BIT: assert property (@(posedge clk) disable iff (!hard_n)
    $countones(fuse_vec ^ $past(fuse_vec)) <= 1) else $error("fuse multi-bit"); // R6
  AST_FUSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!soft_n)
    (fuse_vec != $past(fuse_vec)) |-> blow_req) else $error("fuse w/o req"); // R6
  AST_FUSE_NO_CLEAR: assert property (@(posedge clk) disable iff (!hard_n)
    ((fuse_vec & $past(fuse_vec)) == $past(fuse_vec))) else $error("fuse cleared"); // R6
  AST_BLOW_ONCE: assert property (@(posedge clk) disable iff (!soft_n)
    blow_req |=> !blow_req) else $error("double blow"); // R7
  AST_ACT_UP: assert property (@(posedge clk) disable iff (!soft_n)
    act_vec >= $past(act_vec)) else $error("code fell"); // R4
  AST_ONE_TRIAL: assert property (@(posedge clk) disable iff (!soft_n)
    $onehot0(busy)) else $error("two trials"); // R8
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!soft_n)
    $past(lock_fuse) |-> ($stable(act_vec) && !blow_req)) else $error("lock leak"); // R9
  AST_ERR_NO_BLOW: assert property (@(posedge clk) disable iff (!soft_n)
    $rose(blow_err) |-> !blow_req) else $error("err with blow"); // R10
endmodule

bind trim_prog_ctrl trim_prog_chk u_chk (
  .clk       (clk),
  .hard_n    (hard_n),
  .soft_n    (soft_n),
  .blow_req  (blow_req),
  .blow_err  (blow_err),
  .lock_fuse (lock_fuse),
  .fuse_vec  (fuse_a),
  .act_vec   (act_a)
);

// File: tb/sim_trim_prog_ctrl.sv
`timescale 1ns/1ps
module sim_trim_prog_ctrl;
  logic clk = 1'b0;
  logic hard_rst_n = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic mid_ev = 1'b0;
  logic high_ev = 1'b0;
  logic [7:0] sens_trim;
  logic       uni_mode;
  logic [8:0] qfine_trim;
  logic [3:0] freq_trim;
  logic       cal_hold, locked, blow_req, blow_err;
  logic [2:0] blow_key;
  logic [3:0] blow_bit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  trim_prog_ctrl u0 (
    .clk(clk), .hard_rst_n(hard_rst_n), .pwr_rst_n(pwr_rst_n),
    .mid_ev(mid_ev), .high_ev(high_ev),
    .sens_trim(sens_trim), .uni_mode(uni_mode), .qfine_trim(qfine_trim),
    .freq_trim(freq_trim), .cal_hold(cal_hold), .locked(locked),
    .blow_req(blow_req), .blow_key(blow_key), .blow_bit(blow_bit),
    .blow_err(blow_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mid();
    @(negedge clk); mid_ev = 1'b1;
    @(negedge clk); mid_ev = 1'b0;
  endtask

  task automatic high();
    @(negedge clk); high_ev = 1'b1;
    @(negedge clk); high_ev = 1'b0;
  endtask

  task automatic mids(input int n);
    for (int i = 0; i < n; i++) mid();
  endtask

  task automatic open_key(input int k);
    high();
    mids(k);
    high();
  endtask

  task automatic pwr_cycle();
    @(negedge clk); pwr_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hard_cycle();
    @(negedge clk); hard_rst_n = 1'b0; pwr_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    hard_rst_n = 1'b1; pwr_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int all_trims();
    return {uni_mode, sens_trim, qfine_trim, cal_hold, freq_trim};
  endfunction

  initial begin
    hard_cycle();
    // R1 reset state
    check("R1 trims", all_trims(), 0);
    check("R1 flags", {locked, blow_req, blow_err}, 0);

    // R2 idle mids ignored: 3 idle mids then key 3
    mids(3);
    open_key(3);
    mid();
    check("R2 idle mids ignored", {cal_hold, freq_trim}, 1);

    // R3 null keys and key saturation at 7
    for (int k = 0; k < 10; k++) begin
      if (k == 1 || k == 2 || k == 3) continue;
      pwr_cycle();
      open_key(k);
      mids(3);
      check($sformatf("R3 null/lock key %0d", k), all_trims(), 0);
    end

    // R3 R4 saturating sweeps per register
    pwr_cycle();
    open_key(1);
    for (int n = 1; n <= 514; n++) begin
      mid();
      check("R4 key1 code", {uni_mode, sens_trim}, (n > 511) ? 511 : n);
    end
    check("R3 key1 others", {qfine_trim, cal_hold, freq_trim}, 0);
    pwr_cycle();
    check("R5 trial cleared", all_trims(), 0);
    open_key(2);
    for (int n = 1; n <= 514; n++) begin
      mid();
      check("R4 key2 code", qfine_trim, (n > 511) ? 511 : n);
    end
    pwr_cycle();
    open_key(3);
    for (int n = 1; n <= 36; n++) begin
      mid();
      check("R4 key3 code", {cal_hold, freq_trim}, (n > 31) ? 31 : n);
    end

    // R6 commit freq bit 2
    pwr_cycle();
    open_key(3);
    mids(4);
    high();
    check("R6 blow_req", blow_req, 1);
    check("R6 blow_key", blow_key, 3);
    check("R6 blow_bit", blow_bit, 2);
    check("R6 freq after", freq_trim, 4);
    @(negedge clk);
    check("R6 req one cycle", blow_req, 0);
    mids(3); high();
    check("R7 held freq", freq_trim, 4);
    check("R7 no req", blow_req, 0);
    check("R7 no err", blow_err, 0);
    pwr_cycle();
    check("R6 fuse persists", freq_trim, 4);
    // R8 trial on another register, fuse visible
    open_key(1);
    mids(5);
    check("R8 trial sens", sens_trim, 5);
    check("R8 fused freq", freq_trim, 4);
    pwr_cycle();
    open_key(3);
    mid();
    check("R5 OR of trial and fuse", freq_trim, 5);
    // R10 multi-bit rejection
    mids(2);
    high();
    check("R10 multi err", blow_err, 1);
    check("R10 multi no req", blow_req, 0);
    pwr_cycle();
    check("R10 err cleared", blow_err, 0);
    check("R10 fuse unchanged", {cal_hold, freq_trim}, 4);
    open_key(2); high();
    check("R10 zero code err", blow_err, 1);
    pwr_cycle();
    open_key(6); mids(1); high();
    check("R10 null key err", blow_err, 1);
    hard_cycle();
    check("R6 hard clears fuse", all_trims(), 0);

    // R9 lock: bit 0 rejected, bit 9 accepted
    open_key(5); mid(); high();
    check("R10 lock bit0 err", blow_err, 1);
    check("R10 lock bit0 locked", locked, 0);
    pwr_cycle();
    open_key(5); mids(512); high();
    check("R9 lock req", blow_req, 1);
    check("R9 lock key", blow_key, 5);
    check("R9 lock bit", blow_bit, 9);
    check("R9 locked", locked, 1);
    pwr_cycle();
    check("R9 lock persists", locked, 1);
    open_key(3); mids(4);
    check("R9 frozen trim", all_trims(), 0);
    high();
    check("R9 frozen req", blow_req, 0);
    check("R9 frozen err", blow_err, 0);
    hard_cycle();
    check("R1 unlock on hard", locked, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule